// File: doc/BRIEF.md
# Control Endpoint Handshake Register

This block holds the shared handshake state for the bidirectional control endpoint of a USB device controller. Firmware reaches it over a byte-wide register bus with a write strobe and write data, and reads the status byte back. The USB protocol engine reports what happened on the wire through single-cycle event pulses. These are a packet arriving, a packet leaving, a stall handshake having been sent, a transfer ending too early, and a transfer completing normally.

Each status flag has a fixed owner and a fixed way of being cleared. Some are raised by the engine and dropped by firmware. Some are armed by firmware and dropped by the engine. One is plain read/write. Two write-only service bits exist only to clear flags. Several engine events raise a one-cycle interrupt pulse. A premature end of transfer also issues a one-cycle FIFO flush request, and it holds FIFO access disabled until firmware acknowledges it.

Top module: `ep0_ctl_status`

## Requirements
- R1: After reset the status byte reads 0x00, `irq` and `fifo_flush` are low and `fifo_acc_en` is high. Bits 7 and 6 always read 0.
- R2: Bit 0 (received-packet flag) sets one cycle after `ev_rx_pkt`. It clears one cycle after a write with bit 6 = 1. Writes to bit 0 itself have no effect. If the event and the clearing write occur in the same cycle, the bit ends set.
- R3: Bit 1 (transmit-armed flag) sets one cycle after a write with bit 1 = 1, and writing 0 to bit 1 leaves it unchanged. `ev_tx_done` clears it. A write of 1 in the same cycle as `ev_tx_done` leaves it set.
- R4: Bit 2 (stall-sent flag) sets one cycle after `ev_stall_sent`. A write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. If the event and the clearing write occur in the same cycle, the bit ends set.
- R5: Bit 3 (last-packet flag) sets on a write with bit 3 = 1, and writing 0 has no effect. `ev_xfer_done` clears it. A firmware set in the same cycle as `ev_xfer_done` wins.
- R6: Bit 4 (early-end flag) sets one cycle after `ev_early_end`. A write with bit 7 = 1 clears it. Writes to bit 4 itself have no effect. If the event and the clearing write occur in the same cycle, the bit ends set.
- R7: `fifo_flush` is high for exactly the one cycle after `ev_early_end`. `fifo_acc_en` is low whenever bit 4 reads 1 and high otherwise.
- R8: Bit 5 (stall request) takes the value of bit 5 of every write, one cycle later, and holds between writes.
- R9: `irq` is high for the one cycle after any of `ev_rx_pkt`, `ev_stall_sent` or `ev_early_end`, or after `ev_tx_done` while bit 1 was 1. Otherwise it is low, and firmware writes alone never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Status byte as read by firmware |
| ev_rx_pkt | input | 1 | Engine: valid packet stored in FIFO |
| ev_tx_done | input | 1 | Engine: armed packet delivered to host |
| ev_stall_sent | input | 1 | Engine: transaction aborted with stall |
| ev_early_end | input | 1 | Engine: transfer ended before last-packet flag |
| ev_xfer_done | input | 1 | Engine: transfer completed normally |
| irq | output | 1 | One-cycle interrupt pulse |
| fifo_flush | output | 1 | One-cycle FIFO flush request |
| fifo_acc_en | output | 1 | Firmware FIFO access allowed |

## Verification
The hardest situations to reach are the same-cycle collisions. In these an engine event lands in the very cycle that firmware writes the matching clear, or `ev_tx_done` arrives while the transmit flag is already low so that no interrupt may follow. The stimulus walks every write byte against every combination of the five event pulses, with the strobe both on and off. State is carried from one step to the next, so each collision is met from both a set and a cleared flag. A model in the bench built from the ownership rules predicts every bit.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
   // status flag positions; firmware decodes these
   localparam int unsigned F_RXRDY   = 0;
   localparam int unsigned F_TXARM   = 1;
   localparam int unsigned F_STLSENT = 2;
   localparam int unsigned F_LAST    = 3;
   localparam int unsigned F_EARLY   = 4;
   localparam int unsigned F_STLREQ  = 5;
   localparam int unsigned N_FLAGS   = 6;
   // write-only service strobes
   localparam int unsigned S_ACK_RX    = 6;
   localparam int unsigned S_ACK_EARLY = 7;
   localparam int unsigned MIN_REG_W   = 8;
   // interrupt sources
   localparam int unsigned N_IRQ_SRC = 4;
endpackage

// File: rtl/ep0_flag_cell.sv
module ep0_flag_cell #(
   parameter bit SET_PRIO = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   logic nxt;

   generate
      if (SET_PRIO) begin : g_set_first
         always_comb begin
            nxt = q;
            if (clr_i) nxt = 1'b0;
            if (set_i) nxt = 1'b1;
         end
      end else begin : g_clr_first
         always_comb begin
            nxt = q;
            if (set_i) nxt = 1'b1;
            if (clr_i) nxt = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/ep0_pulse_merge.sv
module ep0_pulse_merge #(
   parameter int unsigned N_SRC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   output logic             pulse_o
);
   generate
      if (N_SRC < 1) begin : g_bad_n
         $error("ep0_pulse_merge needs at least one source");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) pulse_o <= 1'b0;
      else        pulse_o <= |src_i;
   end
endmodule

// File: rtl/ep0_ctl_status.sv
module ep0_ctl_status
   import ep0_csr_pkg::*;
#(
   parameter int unsigned REG_W    = 8,
   parameter bit          SET_PRIO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             ev_rx_pkt,
   input  logic             ev_tx_done,
   input  logic             ev_stall_sent,
   input  logic             ev_early_end,
   input  logic             ev_xfer_done,
   output logic             irq,
   output logic             fifo_flush,
   output logic             fifo_acc_en
);
   localparam int unsigned PAD_W = REG_W - N_FLAGS;

   generate
      if (REG_W < MIN_REG_W) begin : g_bad_w
         $error("ep0_ctl_status: REG_W must hold both service strobes");
      end
   endgenerate

   logic [N_FLAGS-1:0]   set_v;
   logic [N_FLAGS-1:0]   clr_v;
   logic [N_FLAGS-1:0]   flag_q;
   logic [N_IRQ_SRC-1:0] irq_src;

   always_comb begin
      set_v = '0;
      clr_v = '0;
      // engine raises, firmware acknowledges through a service strobe
      set_v[F_RXRDY]   = ev_rx_pkt;
      clr_v[F_RXRDY]   = wr_en & wr_data[S_ACK_RX];
      // firmware arms, engine consumes
      set_v[F_TXARM]   = wr_en & wr_data[F_TXARM];
      clr_v[F_TXARM]   = ev_tx_done;
      // engine raises, firmware writes zero to drop
      set_v[F_STLSENT] = ev_stall_sent;
      clr_v[F_STLSENT] = wr_en & ~wr_data[F_STLSENT];
      // firmware marks final stage, engine drops on completion
      set_v[F_LAST]    = wr_en & wr_data[F_LAST];
      clr_v[F_LAST]    = ev_xfer_done;
      // engine raises on premature end, firmware acknowledges
      set_v[F_EARLY]   = ev_early_end;
      clr_v[F_EARLY]   = wr_en & wr_data[S_ACK_EARLY];
      // plain firmware read/write
      set_v[F_STLREQ]  = wr_en & wr_data[F_STLREQ];
      clr_v[F_STLREQ]  = wr_en & ~wr_data[F_STLREQ];
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_FLAGS; gi++) begin : g_flag
         ep0_flag_cell #(.SET_PRIO(SET_PRIO)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[gi]),
            .clr_i (clr_v[gi]),
            .q     (flag_q[gi])
         );
      end
   endgenerate

   assign irq_src = {ev_tx_done & flag_q[F_TXARM], ev_early_end,
                     ev_stall_sent, ev_rx_pkt};

   ep0_pulse_merge #(.N_SRC(N_IRQ_SRC)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (irq_src),
      .pulse_o (irq)
   );

   ep0_pulse_merge #(.N_SRC(1)) u_flush (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (ev_early_end),
      .pulse_o (fifo_flush)
   );

   assign fifo_acc_en = ~flag_q[F_EARLY];
   assign rd_data     = {{PAD_W{1'b0}}, flag_q};
endmodule

// File: rtl/ep0_ctl_status_chk.sv
module ep0_ctl_status_chk #(
   parameter int unsigned REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             ev_rx_pkt,
   input logic             ev_tx_done,
   input logic             ev_stall_sent,
   input logic             ev_early_end,
   input logic             ev_xfer_done,
   input logic             irq,
   input logic             fifo_flush,
   input logic             fifo_acc_en
);
   assert_rx_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rx_pkt |=> rd_data[0] && irq);

   assert_tx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_done && rd_data[1] && !(wr_en && wr_data[1])) |=> (!rd_data[1] && irq));

   assert_arm_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[1] && !ev_tx_done) |=> rd_data[1]);

   assert_stall_wr0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[2] && !ev_stall_sent) |=> !rd_data[2]);

   assert_last_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_xfer_done && !(wr_en && wr_data[3])) |=> !rd_data[3]);

   assert_early_ign_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[4] && !ev_early_end && !rd_data[4]) |=> !rd_data[4]);

   assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_early_end |=> (fifo_flush && !fifo_acc_en));

   assert_stlreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data[5] == $past(wr_data[5])));

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_rx_pkt && !ev_stall_sent && !ev_early_end && !ev_tx_done) |=> !irq);
endmodule

bind ep0_ctl_status ep0_ctl_status_chk #(.REG_W(REG_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_data       (wr_data),
   .rd_data       (rd_data),
   .ev_rx_pkt     (ev_rx_pkt),
   .ev_tx_done    (ev_tx_done),
   .ev_stall_sent (ev_stall_sent),
   .ev_early_end  (ev_early_end),
   .ev_xfer_done  (ev_xfer_done),
   .irq           (irq),
   .fifo_flush    (fifo_flush),
   .fifo_acc_en   (fifo_acc_en)
);

// File: tb/tb_ep0_ctl_status.sv
`timescale 1ns/1ps
module tb_ep0_ctl_status;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       ev_rx_pkt, ev_tx_done, ev_stall_sent, ev_early_end, ev_xfer_done;
   logic       irq, fifo_flush, fifo_acc_en;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [5:0] exp_s;
   logic       exp_irq;
   logic       exp_flush;

   always #2 clk = ~clk;

   ep0_ctl_status dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .ev_rx_pkt(ev_rx_pkt), .ev_tx_done(ev_tx_done),
      .ev_stall_sent(ev_stall_sent), .ev_early_end(ev_early_end),
      .ev_xfer_done(ev_xfer_done), .irq(irq), .fifo_flush(fifo_flush),
      .fifo_acc_en(fifo_acc_en)
   );

   function automatic string tag_of(int b);
      case (b)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R8";
         default: return "R1";
      endcase
   endfunction

   task automatic check1(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      logic [7:0] exp_byte;
      exp_byte = {2'b00, exp_s};
      for (int b = 0; b < 8; b++) check1(tag_of(b), rd_data[b], exp_byte[b]);
      check1("R9", irq, exp_irq);
      check1("R7", fifo_flush, exp_flush);
      check1("R7", fifo_acc_en, ~exp_s[4]);
   endtask

   // reference step built from the ownership rules
   task automatic model_step(logic w, logic [7:0] d, logic [4:0] e);
      logic rx, tx, stl, early, xd;
      logic [5:0] n;
      {xd, early, stl, tx, rx} = e;
      n = exp_s;
      exp_irq   = rx | stl | early | (tx & exp_s[1]);
      exp_flush = early;
      if (w && d[6]) n[0] = 1'b0;
      if (rx) n[0] = 1'b1;
      if (tx) n[1] = 1'b0;
      if (w && d[1]) n[1] = 1'b1;
      if (w && !d[2]) n[2] = 1'b0;
      if (stl) n[2] = 1'b1;
      if (xd) n[3] = 1'b0;
      if (w && d[3]) n[3] = 1'b1;
      if (w && d[7]) n[4] = 1'b0;
      if (early) n[4] = 1'b1;
      if (w) n[5] = d[5];
      exp_s = n;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
      {ev_xfer_done, ev_early_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = '0;
      exp_s = '0; exp_irq = 1'b0; exp_flush = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      compare_all();
      // sweep every byte x event set x strobe, state carried forward
      for (int d = 0; d < 256; d++) begin
         for (int e = 0; e < 32; e++) begin
            for (int w = 0; w < 2; w++) begin
               @(negedge clk);
               compare_all();
               wr_en   = w[0];
               wr_data = d[7:0];
               {ev_xfer_done, ev_early_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = e[4:0];
               model_step(w[0], d[7:0], e[4:0]);
            end
         end
      end
      @(negedge clk);
      compare_all();
      wr_en = 1'b0;
      {ev_xfer_done, ev_early_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = '0;
      model_step(1'b0, 8'h00, 5'd0);
      @(negedge clk);
      compare_all();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule